// File: doc/BRIEF.md
# Fractional Microsecond Tick Prescaler

This block produces a steady 1 MHz tick from an oscillator clock whose rate need not be a whole multiple of 1 MHz. A 16-bit ratio setting gives the number of oscillator clocks in one repeat period and the number of ticks in that period. A phase accumulator spreads those ticks as evenly as it can across the period. Each tick is a single-cycle pulse. A free-running 32-bit microsecond counter advances by one on every tick.

A freeze input stops the counter and masks the tick. The phase accumulator keeps running during a freeze, so the tick cadence is the same after the freeze ends. Software writes the ratio through a write strobe and a data word. The value it wrote can be read back on a plain output. All pins are plain control and status pins: nothing here is a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `usec_tick_prescaler`

## Requirements
- R1: After reset the ratio setting reads 0x000B, the microsecond counter reads 0 and the tick output is low.
- R2: The ratio setting holds two n+1 encoded fields. Bits [7:0] are the clocks per period minus one (D = bits[7:0] + 1). Bits [15:8] are the ticks per period minus one (N = bits[15:8] + 1). Ticks occur on average once every D/N clocks. Examples: 0x000B gives 12 clocks per tick, and 0x045F gives 5 ticks per 96 clocks.
- R3: Counting from the clock edge that accepted a setting, every run of D consecutive clock edges produces exactly N ticks.
- R4: An accepted write zeroes the phase, and no tick is produced on the write edge. The first tick then appears after edge ceil(D/N) that follows the write edge.
- R5: Each tick is high for exactly one cycle. The tick is never high in two consecutive cycles.
- R6: A write is rejected when 2*N > D. A rejected write leaves both the setting and the phase unchanged, and the tick cadence carries on as though no write had occurred.
- R7: The microsecond counter rises by exactly one in the cycle each tick appears, and it holds its value in every other cycle.
- R8: While freeze is high, the tick stays low and the counter holds its value. The phase keeps advancing, so after freeze drops the ticks fall where they would have fallen without the freeze.
- R9: The readback output shows the last accepted setting from the edge after the write onwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the ratio setting |
| cfg_wdata | input | 16 | Ratio setting to write: [15:8] ticks-1, [7:0] clocks-1 |
| cfg_rdata | output | 16 | Current ratio setting |
| freeze | input | 1 | Holds the counter and masks the tick while high |
| tick | output | 1 | One-cycle 1 MHz tick pulse |
| usec_count | output | 32 | Free-running microsecond counter |

## Verification
A phase accumulator holding the wrong value shows up at the tick pin as a shifted first tick after a write. The offset is visible within ceil(D/N) clocks. A wrong value can also show up as a wrong number of ticks in a D-clock window, and that is visible within one period. A phase that is wrongly cleared or wrongly kept across a rejected write or a freeze moves the next tick by a fixed number of clocks. The checks measure the position of that tick exactly. A fault in the counter appears at once as a mismatch between the rise in the counter and the number of tick pulses seen.

// File: rtl/usp_pkg.sv
package usp_pkg;
  // Width of one n+1 encoded ratio field.
  localparam int unsigned USP_FIELD_W = 8;
  // Width of the free-running microsecond counter.
  localparam int unsigned USP_COUNT_W = 32;
  // Reset ratio: 12 clocks per tick, 1 tick per period.
  localparam logic [2*USP_FIELD_W-1:0] USP_RESET_CFG = 16'h000B;
endpackage

// File: rtl/usp_cfg_reg.sv
module usp_cfg_reg #(
  parameter int unsigned FIELD_W = 8,
  parameter logic [2*FIELD_W-1:0] RESET_CFG = 16'h000B
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [2*FIELD_W-1:0] wdata,
  output logic [2*FIELD_W-1:0] cfg_q,
  output logic                 accept,
  output logic [FIELD_W:0]     num,
  output logic [FIELD_W:0]     den
);
  localparam int unsigned CFG_W = 2 * FIELD_W;
  localparam logic [FIELD_W:0] ONE = 1;

  logic [FIELD_W:0]   wr_num;
  logic [FIELD_W:0]   wr_den;
  logic [FIELD_W+1:0] wr_num_x2;
  logic [FIELD_W+1:0] wr_den_ext;

  // Decode the candidate ratio; reject settings faster than one tick per two clocks.
  assign wr_num     = {1'b0, wdata[CFG_W-1:FIELD_W]} + ONE;
  assign wr_den     = {1'b0, wdata[FIELD_W-1:0]} + ONE;
  assign wr_num_x2  = {wr_num, 1'b0};
  assign wr_den_ext = {1'b0, wr_den};
  assign accept     = we && (wr_num_x2 <= wr_den_ext);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= RESET_CFG;
    end else if (accept) begin
      cfg_q <= wdata;
    end
  end

  assign num = {1'b0, cfg_q[CFG_W-1:FIELD_W]} + ONE;
  assign den = {1'b0, cfg_q[FIELD_W-1:0]} + ONE;

  // R6: a rejected write leaves the setting untouched.
  p_reject_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !accept) |=> $stable(cfg_q));

  // R9: an accepted word is visible on the next cycle.
  p_accept_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (cfg_q == $past(wdata)));
endmodule

// File: rtl/usp_frac_accum.sv
module usp_frac_accum #(
  parameter int unsigned FIELD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             freeze,
  input  logic [FIELD_W:0] num,
  input  logic [FIELD_W:0] den,
  output logic             emit,
  output logic             tick_q
);
  localparam int unsigned ACC_W = FIELD_W + 2;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] den_ext;
  logic [ACC_W-1:0] acc_next;
  logic             hit;

  always_comb begin
    den_ext  = {1'b0, den};
    sum      = acc_q + {1'b0, num};
    hit      = (sum >= den_ext);
    acc_next = hit ? (sum - den_ext) : sum;
  end

  // Tick reaches the counter on the same edge that raises tick_q.
  assign emit = hit && !freeze && !clear;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else if (clear) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= acc_next;
      tick_q <= hit && !freeze;
    end
  end

  // R5: no two ticks in a row.
  p_no_back2back_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q);

  // R3: the phase always stays below one full period.
  p_phase_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < den_ext);

  // R4: an accepted write zeroes the phase and yields no tick.
  p_clear_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (acc_q == '0 && !tick_q));

  // R8: freeze masks the tick.
  p_freeze_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> !tick_q);
endmodule

// File: rtl/usp_us_counter.sv
module usp_us_counter #(
  parameter int unsigned COUNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inc,
  output logic [COUNT_W-1:0] cnt_q
);
  localparam logic [COUNT_W-1:0] STEP = 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (inc) begin
      cnt_q <= cnt_q + STEP;
    end
  end

  // R7: one step per tick.
  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> (cnt_q == $past(cnt_q) + STEP));

  // R7 / R8: hold when no tick is passed on.
  p_count_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(cnt_q));
endmodule

// File: rtl/usec_tick_prescaler.sv
module usec_tick_prescaler
  import usp_pkg::*;
#(
  parameter int unsigned FIELD_W = USP_FIELD_W,
  parameter int unsigned COUNT_W = USP_COUNT_W,
  parameter logic [2*FIELD_W-1:0] RESET_CFG = USP_RESET_CFG
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [2*FIELD_W-1:0] cfg_wdata,
  output logic [2*FIELD_W-1:0] cfg_rdata,
  input  logic                 freeze,
  output logic                 tick,
  output logic [COUNT_W-1:0]   usec_count
);
  logic             accept;
  logic [FIELD_W:0] num;
  logic [FIELD_W:0] den;
  logic             emit;

  usp_cfg_reg #(.FIELD_W(FIELD_W), .RESET_CFG(RESET_CFG)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .cfg_q(cfg_rdata), .accept(accept), .num(num), .den(den)
  );

  usp_frac_accum #(.FIELD_W(FIELD_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(accept), .freeze(freeze),
    .num(num), .den(den), .emit(emit), .tick_q(tick)
  );

  usp_us_counter #(.COUNT_W(COUNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(emit), .cnt_q(usec_count)
  );

  // R7: the counter moves exactly in the cycles the tick is high.
  p_tick_moves_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (usec_count != $past(usec_count)));

  // R1: reset state is visible on the first cycle after reset.
  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (cfg_rdata == RESET_CFG && usec_count == '0 && !tick));
endmodule

// File: tb/sim_usec_tick_prescaler.sv
`timescale 1ns/1ps
module sim_usec_tick_prescaler;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        freeze = 1'b0;
  logic        tick;
  logic [31:0] usec_count;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  usec_tick_prescaler u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .freeze(freeze), .tick(tick), .usec_count(usec_count)
  );

  // Table: setting, ticks per period (N), clocks per period (D), first tick = ceil(D/N).
  localparam int NV = 8;
  localparam logic [15:0] V_CFG [0:NV-1] = '{16'h000B, 16'h043F, 16'h000C, 16'h0453,
                                             16'h045F, 16'h0019, 16'h04BF, 16'h002F};
  localparam int V_N [0:NV-1]     = '{1, 5, 1, 5, 5, 1, 5, 1};
  localparam int V_D [0:NV-1]     = '{12, 64, 13, 84, 96, 26, 192, 48};
  localparam int V_FIRST [0:NV-1] = '{12, 13, 13, 17, 20, 26, 39, 48};

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Observe n cycles: number of ticks, index of first tick, back-to-back flag.
  task automatic observe(input int n, output int nt, output int first, output bit b2b);
    bit prev = 1'b0;
    nt = 0; first = 0; b2b = 1'b0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (tick) begin
        nt++;
        if (first == 0) first = k;
        if (prev) b2b = 1'b1;
      end
      prev = tick;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int nt, first;
    bit b2b;
    logic [31:0] c0;
    bit frz_ok;

    // R1: reset state.
    repeat (3) @(negedge clk);
    check(cfg_rdata == 16'h000B, "R1 cfg", cfg_rdata, 16'h000B);
    check(usec_count == 0, "R1 count", usec_count, 0);
    check(tick == 1'b0, "R1 tick", tick, 0);
    rst_n = 1'b1;
    observe(12, nt, first, b2b);
    check(first == 12 && nt == 1, "R1 first tick after reset", first, 12);

    // Table walk: R2, R3, R4, R5, R7, R9.
    for (int i = 0; i < NV; i++) begin
      write_cfg(V_CFG[i]);
      check(tick == 1'b0, "R4 no tick on write edge", tick, 0);
      check(cfg_rdata == V_CFG[i], "R9 readback", cfg_rdata, V_CFG[i]);
      c0 = usec_count;
      observe(4 * V_D[i], nt, first, b2b);
      check(first == V_FIRST[i], "R4 first tick", first, V_FIRST[i]);
      check(nt == 4 * V_N[i], "R2 R3 ticks per window", nt, 4 * V_N[i]);
      check(!b2b, "R5 no back-to-back", b2b, 0);
      check(usec_count - c0 == nt, "R7 count step", usec_count - c0, nt);
    end

    // R6: rejected write keeps setting and phase.
    write_cfg(16'h045F);
    observe(25, nt, first, b2b);
    write_cfg(16'h0A0B);
    check(cfg_rdata == 16'h045F, "R6 setting kept", cfg_rdata, 16'h045F);
    observe(20, nt, first, b2b);
    check(first == 12, "R6 phase kept", first, 12);

    // R6 boundary: N=2, D=3 rejected; N=1, D=2 accepted.
    write_cfg(16'h0102);
    check(cfg_rdata == 16'h045F, "R6 boundary reject", cfg_rdata, 16'h045F);
    write_cfg(16'h0001);
    check(cfg_rdata == 16'h0001, "R9 boundary accept", cfg_rdata, 16'h0001);
    observe(10, nt, first, b2b);
    check(nt == 5 && first == 2 && !b2b, "R5 two-clock cadence", nt, 5);

    // R8: freeze holds count, masks tick, keeps phase.
    write_cfg(16'h000B);
    observe(5, nt, first, b2b);
    freeze = 1'b1;
    c0 = usec_count;
    frz_ok = 1'b1;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (tick || usec_count != c0) frz_ok = 1'b0;
    end
    check(frz_ok, "R8 frozen", usec_count, c0);
    freeze = 1'b0;
    observe(1, nt, first, b2b);
    check(first == 1, "R8 phase kept", first, 1);
    check(usec_count == c0 + 1, "R7 R8 count after freeze", usec_count, c0 + 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule